// File: doc/BRIEF.md
# Preferred Reference Source Selector

This block picks which timing reference (a 10 MHz frequency source together with its matching pulse-per-second line) feeds a clock distribution stage. Two candidate sources exist: an internal one and an external one. Each has a presence flag. A front-panel preference switch chooses which source should win when both are usable. When the preferred source is missing, the block falls back to the other one. When neither source is present, it blanks the status lights and leaves the last selection in place.

A separate programmer loads one of two configuration tables into the distribution device. This block tells it which table to load and sends it a one-cycle request pulse. The block also drives the PPS multiplexer select line and three status LEDs.

A decision is made again only when one of two things changes: the synchronized switch level, or the external-presence flag. A change in the internal-presence flag alone never triggers a new decision. After reset, one evaluation is forced. While the programmer reports busy, a pending evaluation waits and is carried out in the first cycle in which busy is low.

Top module: `refsel_top`

## Requirements
- R1: While reset is asserted, and until the first evaluation, `sel_ext_o`=0, `pps_sel_o`=1, `led_o`=3'b110 and `prog_req_o`=0. In `led_o`, bit 2 is the top LED, bit 1 the middle LED and bit 0 the bottom LED.
- R2: `pref_sw_i` low means internal is preferred and high means external is preferred. The level is used only after it passes through a two-flop synchronizer.
- R3: With internal preferred, the block selects internal if `int_ok_i`=1. Otherwise it selects external if `ext_ok_i`=1. Otherwise it takes the no-source action.
- R4: With external preferred, the block selects external if `ext_ok_i`=1. Otherwise it selects internal if `int_ok_i`=1. Otherwise it takes the no-source action.
- R5: Selecting internal drives `led_o`=3'b101, `pps_sel_o`=1 and `sel_ext_o`=0, and raises `prog_req_o` for exactly one cycle.
- R6: Selecting external drives `led_o`=3'b011, `pps_sel_o`=0 and `sel_ext_o`=1, and raises `prog_req_o` for exactly one cycle. Whenever the selection is held, `pps_sel_o` is the inverse of `sel_ext_o`.
- R7: The no-source action drives `led_o`=3'b000. It keeps `sel_ext_o` and `pps_sel_o` at their previous values and issues no request.
- R8: An evaluation runs only when the synchronized switch or `ext_ok_i` differs from the value recorded at the last evaluation. A change of `int_ok_i` alone changes no output.
- R9: The first evaluation after reset always runs, whatever the input levels, once the synchronizer has filled.
- R10: While `prog_busy_i`=1, no evaluation runs and no request is issued. A pending evaluation runs in the first cycle in which busy is low, using the inputs of that cycle.
- R11: A change of `ext_ok_i` is reflected at the outputs after one rising edge. A change of `pref_sw_i` is reflected after three rising edges. After reset is released, the first evaluation appears after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pref_sw_i | input | 1 | Preference switch; asynchronous, low = internal preferred |
| int_ok_i | input | 1 | Internal source present (synchronous) |
| ext_ok_i | input | 1 | External source present (synchronous) |
| prog_busy_i | input | 1 | Programmer is busy; holds off evaluation |
| sel_ext_o | output | 1 | Table choice for the programmer: 1 = external, 0 = internal |
| prog_req_o | output | 1 | One-cycle request to start reprogramming |
| pps_sel_o | output | 1 | PPS multiplexer select: 1 = internal, 0 = external |
| led_o | output | 3 | Status LEDs: [2] top, [1] middle, [0] bottom |

## Verification
The recorded switch and external values decide whether anything happens. A wrong record shows up in one of two ways: an evaluation that never fires, or an extra request pulse. An internal-presence toggle, or a no-change window, exposes this within one to three cycles of the stimulus. A wrong primed flag after reset shows as the reset LED pattern persisting past the third edge. A fallback error shows as the wrong LED pattern and table choice on the very cycle of the request. A broken busy hold shows as a request pulse while busy is high, or a missing one in the cycle after busy falls.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int LED_W = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

    localparam logic [LED_W-1:0] LED_BOOT = 3'b110;
    localparam logic [LED_W-1:0] LED_INT  = 3'b101;
    localparam logic [LED_W-1:0] LED_EXT  = 3'b011;
    localparam logic [LED_W-1:0] LED_DARK = 3'b000;

    typedef struct packed {
        logic             sel_ext;
        logic             pps_int;
        logic [LED_W-1:0] led;
        logic             req;
    } out_t;

    typedef struct packed {
        logic primed;
        logic last_sw;
        logic last_ext;
    } trig_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic valid_o
);
    logic [STAGES-1:0] shift_d, shift_q;
    logic [STAGES-1:0] fill_d, fill_q;

    always_comb begin
        shift_d = {shift_q[STAGES-2:0], async_i};
        fill_d  = {fill_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            fill_q  <= '0;
        end else begin
            shift_q <= shift_d;
            fill_q  <= fill_d;
        end
    end

    assign sync_o  = shift_q[STAGES-1];
    assign valid_o = fill_q[STAGES-1];
endmodule

// File: rtl/refsel_trigger.sv
module refsel_trigger
    import refsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_i,
    input  logic sw_valid_i,
    input  logic ext_i,
    input  logic busy_i,
    output logic fire_o
);
    trig_t st_d, st_q;
    logic  differs;

    always_comb begin
        st_d    = st_q;
        differs = !st_q.primed || (sw_i != st_q.last_sw) || (ext_i != st_q.last_ext);
        fire_o  = sw_valid_i && differs && !busy_i;
        if (fire_o) begin
            st_d.primed   = 1'b1;
            st_d.last_sw  = sw_i;
            st_d.last_ext = ext_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/refsel_decide.sv
module refsel_decide
    import refsel_pkg::*;
(
    input  logic pref_ext_i,
    input  logic int_ok_i,
    input  logic ext_ok_i,
    output src_e src_o
);
    logic [1:0] order_ok;

    always_comb begin
        order_ok = pref_ext_i ? {ext_ok_i, int_ok_i} : {int_ok_i, ext_ok_i};
        if (order_ok[1])      src_o = pref_ext_i ? SRC_EXT : SRC_INT;
        else if (order_ok[0]) src_o = pref_ext_i ? SRC_INT : SRC_EXT;
        else                  src_o = SRC_NONE;
    end
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pref_sw_i,
    input  logic             int_ok_i,
    input  logic             ext_ok_i,
    input  logic             prog_busy_i,
    output logic             sel_ext_o,
    output logic             prog_req_o,
    output logic             pps_sel_o,
    output logic [LED_W-1:0] led_o
);
    logic sw_s, sw_valid, fire;
    src_e src;
    out_t out_d, out_q;

    refsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pref_sw_i),
        .sync_o  (sw_s),
        .valid_o (sw_valid)
    );

    refsel_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_i       (sw_s),
        .sw_valid_i (sw_valid),
        .ext_i      (ext_ok_i),
        .busy_i     (prog_busy_i),
        .fire_o     (fire)
    );

    refsel_decide u_dec (
        .pref_ext_i (sw_s),
        .int_ok_i   (int_ok_i),
        .ext_ok_i   (ext_ok_i),
        .src_o      (src)
    );

    always_comb begin
        out_d     = out_q;
        out_d.req = 1'b0;
        if (fire) begin
            unique case (src)
                SRC_INT: begin
                    out_d.sel_ext = 1'b0;
                    out_d.pps_int = 1'b1;
                    out_d.led     = LED_INT;
                    out_d.req     = 1'b1;
                end
                SRC_EXT: begin
                    out_d.sel_ext = 1'b1;
                    out_d.pps_int = 1'b0;
                    out_d.led     = LED_EXT;
                    out_d.req     = 1'b1;
                end
                default: out_d.led = LED_DARK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.sel_ext <= 1'b0;
            out_q.pps_int <= 1'b1;
            out_q.led     <= LED_BOOT;
            out_q.req     <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_ext_o  = out_q.sel_ext;
    assign pps_sel_o  = out_q.pps_int;
    assign led_o      = out_q.led;
    assign prog_req_o = out_q.req;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_busy_i,
    input logic       prog_req_o,
    input logic       sel_ext_o,
    input logic       pps_sel_o,
    input logic [2:0] led_o
);
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(!prog_busy_i)); // R10

    AST_INT_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o && !sel_ext_o) |-> (led_o == 3'b101 && pps_sel_o)); // R5

    AST_EXT_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o && sel_ext_o) |-> (led_o == 3'b011 && !pps_sel_o)); // R6

    AST_SEL_PPS_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        pps_sel_o == !sel_ext_o); // R6

    AST_DARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o == 3'b000 && $past(led_o) != 3'b000)
            |-> (!prog_req_o && $stable(sel_ext_o) && $stable(pps_sel_o))); // R7
endmodule

bind refsel_top refsel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_busy_i (prog_busy_i),
    .prog_req_o  (prog_req_o),
    .sel_ext_o   (sel_ext_o),
    .pps_sel_o   (pps_sel_o),
    .led_o       (led_o)
);

// File: tb/sim_refsel_top.sv
module sim_refsel_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       sw;
        logic       io;
        logic       eo;
        logic [2:0] led;
        logic       sel;
        logic       pps;
        logic [1:0] nreq;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 1'b1, 2'd1},
        '{1'b1, 1'b1, 1'b1, 3'b011, 1'b1, 1'b0, 2'd1},
        '{1'b1, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 2'd1},
        '{1'b1, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 2'd0},
        '{1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 2'd0},
        '{1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 1'b1, 2'd1},
        '{1'b0, 1'b0, 1'b1, 3'b101, 1'b0, 1'b1, 2'd0},
        '{1'b1, 1'b0, 1'b1, 3'b011, 1'b1, 1'b0, 2'd1},
        '{1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b1, 1'b1, 3'b011, 1'b1, 1'b0, 2'd1},
        '{1'b0, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pref_sw_i = 1'b0;
    logic       int_ok_i = 1'b1;
    logic       ext_ok_i = 1'b0;
    logic       prog_busy_i = 1'b0;
    logic       sel_ext_o, prog_req_o, pps_sel_o;
    logic [2:0] led_o;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refsel_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pref_sw_i   (pref_sw_i),
        .int_ok_i    (int_ok_i),
        .ext_ok_i    (ext_ok_i),
        .prog_busy_i (prog_busy_i),
        .sel_ext_o   (sel_ext_o),
        .prog_req_o  (prog_req_o),
        .pps_sel_o   (pps_sel_o),
        .led_o       (led_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [2:0] led, input logic sel,
                           input logic pps, input logic req);
        chk({tag, " led"}, int'(led_o), int'(led));
        chk({tag, " sel"}, int'(sel_ext_o), int'(sel));
        chk({tag, " pps"}, int'(pps_sel_o), int'(pps));
        chk({tag, " req"}, int'(prog_req_o), int'(req));
    endtask

    task automatic step(input int n, inout int pulses);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            if (prog_req_o) pulses++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        chk_out("R1 reset state", 3'b110, 1'b0, 1'b1, 1'b0);

        // First evaluation after release: sw=0 int=1 ext=0 -> internal
        rst_n = 1'b1;
        p = 0;
        step(2, p);
        chk_out("R11 before first eval", 3'b110, 1'b0, 1'b1, 1'b0);
        step(1, p);
        chk_out("R9 first eval internal", 3'b101, 1'b0, 1'b1, 1'b1);
        step(1, p);
        chk("R5 request one cycle", int'(prog_req_o), 0);

        // Vector table: R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            pref_sw_i = VEC[i].sw;
            int_ok_i  = VEC[i].io;
            ext_ok_i  = VEC[i].eo;
            p = 0;
            step(5, p);
            chk($sformatf("R3/R4/R7/R8 vec%0d led", i), int'(led_o), int'(VEC[i].led));
            chk($sformatf("R2/R6 vec%0d sel", i), int'(sel_ext_o), int'(VEC[i].sel));
            chk($sformatf("R5/R6 vec%0d pps", i), int'(pps_sel_o), int'(VEC[i].pps));
            chk($sformatf("R8 vec%0d pulses", i), p, int'(VEC[i].nreq));
        end

        // Busy holds evaluation (R10); state now sw0 int1 ext0 internal
        prog_busy_i = 1'b1;
        pref_sw_i   = 1'b1;
        ext_ok_i    = 1'b1;
        p = 0;
        step(6, p);
        chk("R10 no request while busy", p, 0);
        chk("R10 outputs held while busy", int'(led_o), 3'b101);
        prog_busy_i = 1'b0;
        p = 0;
        step(1, p);
        chk_out("R10 eval after busy clears", 3'b011, 1'b1, 1'b0, 1'b1);
        step(1, p);
        chk("R6 request one cycle", int'(prog_req_o), 0);

        // External flag latency (R11): pref ext, ext gone, int present -> internal
        ext_ok_i = 1'b0;
        p = 0;
        step(1, p);
        chk_out("R11 ext change one edge", 3'b101, 1'b0, 1'b1, 1'b1);

        // Second reset with external preferred (R9, R1)
        rst_n     = 1'b0;
        pref_sw_i = 1'b1;
        ext_ok_i  = 1'b1;
        p = 0;
        step(2, p);
        chk_out("R1 reset state again", 3'b110, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(3, p);
        chk_out("R9 first eval external", 3'b011, 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule